// File: doc/BRIEF.md
# Cartridge Bank Controller

This block sits on the write side of a cartridge slot for a small handheld console. It snoops CPU writes in the lower half of the 16-bit address space (0x0000 to 0x7FFF), where the cartridge has no writable memory, and treats them as commands. From those commands it keeps four pieces of state: a 5-bit low ROM bank field, a 2-bit secondary field, a banking-mode bit and a RAM access flag. It drives the bank number for the switchable ROM window and the bank number for external RAM. The ROM and RAM arrays and the CPU read multiplexing live elsewhere.

The 2-bit secondary field has two possible destinations. In mode 0 it extends the ROM bank to 7 bits; in mode 1 it selects one of four RAM banks. A write to the mode region clears whichever destination the new mode no longer uses. A size input gives log2 of the number of ROM banks present, and the driven ROM bank is folded into that range so that a request beyond the end of the ROM wraps instead of addressing nothing.

The write port is a plain strobe with no back-pressure: every write with the strobe high is taken in the cycle it appears. All outputs are registers, so nothing downstream sees a combinational path from the CPU bus.

Top module: `cart_bank_ctrl`

## Requirements
- R1: A write is decoded by address bits 15:13: value 0 (0x0000 to 0x1FFF) is the RAM access region, 1 (0x2000 to 0x3FFF) the low ROM bank region, 2 (0x4000 to 0x5FFF) the secondary field region and 3 (0x6000 to 0x7FFF) the mode region; a write with address bit 15 set, or any cycle with the strobe low, changes no state.
- R2: After reset the driven ROM bank is 1, the RAM bank is 0, RAM access is off and the mode is 0.
- R3: A write to the low ROM bank region loads data bits 4:0 into ROM bank bits 4:0 and keeps ROM bank bits 6:5; a data value whose bits 4:0 are all zero loads 1 instead.
- R4: A write to the RAM access region with data 0x0A turns RAM access on, with data 0x00 turns it off, and with any other value leaves it as it was.
- R5: In mode 0 a write to the secondary region loads data bits 1:0 into ROM bank bits 6:5 and leaves the RAM bank unchanged.
- R6: In mode 1 a write to the secondary region loads data bits 1:0 into the RAM bank and leaves the ROM bank unchanged.
- R7: A write to the mode region with data bit 0 set selects mode 1 and clears ROM bank bits 6:5.
- R8: A write to the mode region with data bit 0 clear selects mode 0 and forces the RAM bank to 0.
- R9: The driven ROM bank equals the requested 7-bit bank ANDed with 2^n − 1, where n (0 to 7) is the size input.
- R10: A write sampled at a rising clock edge is visible on the outputs right after that same edge; a change of the size input shows after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe, one write per high cycle |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| rom_size_log2 | input | 3 | log2 of the number of ROM banks fitted |
| rom_bank | output | 7 | Registered bank number for the switchable ROM window |
| ram_bank | output | 2 | Registered external RAM bank number |
| ram_en | output | 1 | Registered RAM access flag |

## Verification
Every piece of internal state reaches a port within one edge: the low field and upper bits appear directly in the ROM bank, the RAM bank and access flag are outputs, and the mode, which has no port of its own, reveals itself on the very next secondary-region write by steering that write to the wrong output. A stale or wrongly cleared destination after a mode write therefore shows up as a mismatch on the first following secondary write, or at once where the mode write itself clears bits. A mask error only shows when the requested bank exceeds the fitted size, so the size input is swept across small values while the upper bits are set.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

  // Field widths of the bank state
  localparam int LO_W      = 5;
  localparam int SEC_W     = 2;
  localparam int ROM_BANK_W = LO_W + SEC_W;

  // Data codes in the RAM access region
  localparam logic [7:0] RAM_UNLOCK = 8'h0A;
  localparam logic [7:0] RAM_LOCK   = 8'h00;

  // Region index carried by address bits 14:13 (bit 15 low)
  typedef enum logic [1:0] {
    RGN_RAM_ACC = 2'd0,
    RGN_ROM_LO  = 2'd1,
    RGN_SECOND  = 2'd2,
    RGN_MODE    = 2'd3
  } region_e;

  typedef struct packed {
    logic ram_acc;
    logic rom_lo;
    logic second;
    logic mode;
  } wr_hit_t;

  typedef struct packed {
    logic             ram_en;
    logic             mode;
    logic [SEC_W-1:0] ram;
    logic [SEC_W-1:0] hi;
    logic [LO_W-1:0]  lo;
  } bank_state_t;

  localparam bank_state_t STATE_RESET = '{
    ram_en: 1'b0, mode: 1'b0, ram: '0, hi: '0, lo: LO_W'(1)
  };

endpackage

// File: rtl/cbc_wr_decode.sv
module cbc_wr_decode
  import cbc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output wr_hit_t           hit
);

  localparam int NUM_RGN = 4;

  logic              in_ctrl_space;
  logic [1:0]        rgn_sel;
  logic [NUM_RGN-1:0] rgn_vec;

  assign in_ctrl_space = wr_en && !wr_addr[ADDR_W-1];
  assign rgn_sel       = wr_addr[ADDR_W-2:ADDR_W-3];

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
    assign rgn_vec[g] = in_ctrl_space && (rgn_sel == 2'(g));
  end

  assign hit.ram_acc = rgn_vec[RGN_RAM_ACC];
  assign hit.rom_lo  = rgn_vec[RGN_ROM_LO];
  assign hit.second  = rgn_vec[RGN_SECOND];
  assign hit.mode    = rgn_vec[RGN_MODE];

endmodule

// File: rtl/cbc_bank_regs.sv
module cbc_bank_regs
  import cbc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wr_hit_t           hit,
  input  logic [DATA_W-1:0] wr_data,
  output bank_state_t       st_nxt,
  output bank_state_t       st_q
);

  logic [LO_W-1:0]  lo_field;
  logic [SEC_W-1:0] sec_field;

  assign lo_field  = wr_data[LO_W-1:0];
  assign sec_field = wr_data[SEC_W-1:0];

  always_comb begin
    st_nxt = st_q;
    if (hit.ram_acc) begin
      if (wr_data == DATA_W'(RAM_UNLOCK))
        st_nxt.ram_en = 1'b1;
      else if (wr_data == DATA_W'(RAM_LOCK))
        st_nxt.ram_en = 1'b0;
    end
    if (hit.rom_lo) begin
      st_nxt.lo = (lo_field == '0) ? LO_W'(1) : lo_field;
    end
    if (hit.second) begin
      if (st_q.mode)
        st_nxt.ram = sec_field;
      else
        st_nxt.hi = sec_field;
    end
    if (hit.mode) begin
      st_nxt.mode = wr_data[0];
      if (wr_data[0])
        st_nxt.hi = '0;
      else
        st_nxt.ram = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= STATE_RESET;
    else        st_q <= st_nxt;
  end

  // R4
  ram_en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit.ram_acc |=> $stable(st_q.ram_en));

  // R3
  lo_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_q.lo != '0);

  // R7
  mode1_hi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_q.mode |-> st_q.hi == '0);

  // R8
  mode0_ram_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !st_q.mode |-> st_q.ram == '0);

  // R6
  mode1_rom_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit.second && st_q.mode && !hit.mode && !hit.rom_lo) |=> $stable({st_q.hi, st_q.lo}));

endmodule

// File: rtl/cbc_rom_fold.sv
module cbc_rom_fold #(
  parameter int BANK_W = 7,
  parameter int SIZE_W = 3
) (
  input  logic [BANK_W-1:0] bank_req,
  input  logic [SIZE_W-1:0] size_log2,
  output logic [BANK_W-1:0] bank_fold
);

  // Bit i survives only if the fitted bank count exceeds 2^i
  for (genvar i = 0; i < BANK_W; i++) begin : g_bit
    assign bank_fold[i] = bank_req[i] && (32'(size_log2) > i);
  end

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SIZE_W = $clog2(ROM_BANK_W + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [SIZE_W-1:0]     rom_size_log2,
  output logic [ROM_BANK_W-1:0] rom_bank,
  output logic [SEC_W-1:0]      ram_bank,
  output logic                  ram_en
);

  wr_hit_t               hit;
  bank_state_t           st_nxt;
  bank_state_t           st_q;
  logic [ROM_BANK_W-1:0] rom_req;
  logic [ROM_BANK_W-1:0] rom_fold;

  cbc_wr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .hit     (hit)
  );

  cbc_bank_regs #(.DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (hit),
    .wr_data (wr_data),
    .st_nxt  (st_nxt),
    .st_q    (st_q)
  );

  assign rom_req = {st_nxt.hi, st_nxt.lo};

  cbc_rom_fold #(.BANK_W(ROM_BANK_W), .SIZE_W(SIZE_W)) u_fold (
    .bank_req  (rom_req),
    .size_log2 (rom_size_log2),
    .bank_fold (rom_fold)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rom_bank <= ROM_BANK_W'(1);
      ram_bank <= '0;
      ram_en   <= 1'b0;
    end else begin
      rom_bank <= rom_fold;
      ram_bank <= st_nxt.ram;
      ram_en   <= st_nxt.ram_en;
    end
  end

  // R1
  no_write_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || wr_addr[ADDR_W-1]) |=> $stable(st_q));

  // R9
  rom_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (({1'b0, rom_bank} >> $past(rom_size_log2)) == '0));

  // R10
  ram_out_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (ram_bank == st_q.ram) && (ram_en == st_q.ram_en));

endmodule

// File: tb/cart_bank_ctrl_bench.sv
module cart_bank_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rom_size_log2 = 3'd7;
  logic [6:0] rom_bank;
  logic [1:0] ram_bank;
  logic       ram_en;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;
  bit model_live = 1'b0;

  // behavioural reference state
  int m_lo, m_hi, m_ram, m_mode, m_en;
  int e_rom, e_ram, e_en;

  always #4 clk = ~clk;

  cart_bank_ctrl u_cart_bank_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .rom_size_log2 (rom_size_log2),
    .rom_bank      (rom_bank),
    .ram_bank      (ram_bank),
    .ram_en        (ram_en)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lo = 1; m_hi = 0; m_ram = 0; m_mode = 0; m_en = 0;
      e_rom = 1; e_ram = 0; e_en = 0;
    end else begin
      if (wr_en && wr_addr < 16'h8000) begin
        case (int'(wr_addr) / 8192)
          0: begin
            if (wr_data == 8'h0A) m_en = 1;
            else if (wr_data == 8'h00) m_en = 0;
          end
          1: m_lo = (int'(wr_data) % 32 == 0) ? 1 : int'(wr_data) % 32;
          2: if (m_mode == 1) m_ram = int'(wr_data) % 4; else m_hi = int'(wr_data) % 4;
          default: begin
            m_mode = int'(wr_data) % 2;
            if (m_mode == 1) m_hi = 0; else m_ram = 0;
          end
        endcase
      end
      e_rom = (m_hi * 32 + m_lo) % (1 << rom_size_log2);
      e_ram = m_ram;
      e_en  = m_en;
    end
  end

  task automatic check_val(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic expect_out(string tag, int rom, int ram, int en);
    check_val(tag, "rom_bank", int'(rom_bank), rom);
    check_val(tag, "ram_bank", int'(ram_bank), ram);
    check_val(tag, "ram_en", int'(ram_en), en);
  endtask

  // per-clock comparison against the reference (R10)
  always @(negedge clk) begin
    if (model_live && rst_n && !done) begin
      check_val("R10", "model rom_bank", int'(rom_bank), e_rom);
      check_val("R10", "model ram_bank", int'(ram_bank), e_ram);
      check_val("R10", "model ram_en", int'(ram_en), e_en);
    end
  end

  task automatic write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    model_live = 1'b1;
    idle(1);
    expect_out("R2", 1, 0, 0);

    write(16'h0000, 8'h0A); expect_out("R4", 1, 0, 1);
    write(16'h1FFF, 8'h05); expect_out("R4", 1, 0, 1);
    write(16'h0123, 8'h00); expect_out("R4", 1, 0, 0);
    write(16'h1000, 8'h0A); expect_out("R4", 1, 0, 1);

    write(16'h2000, 8'h00); expect_out("R3", 1, 0, 1);
    write(16'h3FFF, 8'hF3); expect_out("R3", 8'h13, 0, 1);
    write(16'h4000, 8'h02); expect_out("R5", 8'h53, 0, 1);
    write(16'h2100, 8'h04); expect_out("R3", 8'h44, 0, 1);
    write(16'h2100, 8'h20); expect_out("R3", 8'h41, 0, 1);
    write(16'h2100, 8'h04); expect_out("R3", 8'h44, 0, 1);

    // strobe low and upper-half addresses leave everything alone
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 16'h2000; wr_data = 8'h07;
    idle(2);
    expect_out("R1", 8'h44, 0, 1);
    write(16'h8000, 8'h00); expect_out("R1", 8'h44, 0, 1);
    write(16'hA000, 8'h00); expect_out("R1", 8'h44, 0, 1);
    write(16'hE000, 8'h01); expect_out("R1", 8'h44, 0, 1);

    write(16'h6000, 8'h01); expect_out("R7", 8'h04, 0, 1);
    write(16'h4000, 8'h03); expect_out("R6", 8'h04, 3, 1);
    write(16'h5FFF, 8'hFE); expect_out("R6", 8'h04, 2, 1);
    write(16'h6000, 8'h00); expect_out("R8", 8'h04, 0, 1);
    write(16'h4000, 8'h01); expect_out("R5", 8'h24, 0, 1);
    write(16'h7FFF, 8'hFE); expect_out("R8", 8'h24, 0, 1);

    // size folding; the new size shows after the next edge
    @(negedge clk); rom_size_log2 = 3'd4;
    @(negedge clk); expect_out("R9", 8'h04, 0, 1);
    @(negedge clk); rom_size_log2 = 3'd2;
    @(negedge clk); expect_out("R9", 0, 0, 1);
    write(16'h2000, 8'h07); expect_out("R9", 3, 0, 1);
    @(negedge clk); rom_size_log2 = 3'd0;
    @(negedge clk); expect_out("R9", 0, 0, 1);
    @(negedge clk); rom_size_log2 = 3'd7;
    @(negedge clk); expect_out("R9", 8'h27, 0, 1);

    // reset again mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); expect_out("R2", 1, 0, 0);
    rst_n = 1'b1;
    write(16'h4000, 8'h03); expect_out("R2", 8'h61, 0, 0);

    idle(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule